// File: doc/BRIEF.md
# Cache-Operation Access Protection Checker

This block sits beside the data-side memory unit and gives a verdict on each cache-management, string or ordinary load/store operation. Each operation comes with its class code, the privilege state, the translation enable and the TLB lookup result: hit flag, write permission of the hit entry and the two-bit zone-protection field chosen for it. It also carries the string transfer byte count. From these the block decides whether the operation raises a data storage exception, raises a TLB miss exception, is quietly dropped as a no-op, or goes ahead.

Each class follows its own rules. Some behave as loads and some as stores. Touch operations are speculative and are dropped rather than faulted. Privileged maintenance operations are not subject to zone protection. Zero-length string operations never touch memory.

The input side has no back-pressure. An operation is accepted on every clock edge where `in_valid` is high, and there is no ready signal. The verdict appears on the four result flags for exactly one cycle, in the cycle after acceptance. A new operation may be presented on every cycle. Address translation, the TLB itself and the cache data paths live elsewhere.

Top module: `apc_checker`

## Requirements
- R1: The result flags are registered. An operation accepted at a clock edge produces its verdict during the following cycle only. In a cycle after an edge with `in_valid` low, all four flags are 0, and reset clears them to 0.
- R2: For every accepted operation, exactly one of `out_dsi`, `out_tlb_miss`, `out_nop` and `out_proceed` is 1.
- R3: With `in_xlate` = 0 (real mode), no data storage or TLB miss exception is ever raised. Every class asserts `out_proceed`, except a zero-length string operation (R11).
- R4: With `in_xlate` = 1 and `in_tlb_hit` = 0, any class that does consult the TLB raises only `out_tlb_miss`. The touch classes (R7), the read classes (R9) and zero-length strings (R11) do not consult it.
- R5: Class 0 is an ordinary load and faults only when the zone field is 2'b00 in user mode (`in_priv` = 0). Class 1 is an ordinary store and faults on a user-mode zone 2'b00 or on `in_wr_ok` = 0.
- R6: Class 2, the data-cache congruence-class invalidate, faults with a data storage exception when `in_wr_ok` = 0. It never faults for zone 2'b00, even in user mode.
- R7: Classes 3, 4 and 9 (data touch, data touch-for-store, instruction touch) never raise an exception. A TLB miss or a user-mode zone 2'b00 turns them into `out_nop`. Otherwise they proceed.
- R8: Classes 5, 6 and 8 (data flush, data store-block, instruction block invalidate) act as loads. `in_wr_ok` = 0 never faults them, and a user-mode zone 2'b00 raises a data storage exception.
- R9: Classes 7 and 11 (data-cache read, instruction-cache read) never raise either exception and always proceed.
- R10: Class 10, the instruction-cache congruence-class invalidate, never raises a data storage exception, whatever the zone or write permission. It can raise a TLB miss.
- R11: Classes 12 (string store) and 13 (string load) with `in_byte_cnt` = 0 give `out_nop` and never an exception. With a non-zero count, class 12 follows the store rules of R5 and class 13 the load rules.
- R12: Codes 14 and 15 are reserved and follow the ordinary load rules of R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation presented this cycle; always accepted |
| in_class | input | 4 | Operation class code (see requirements) |
| in_priv | input | 1 | 1 = supervisor mode |
| in_xlate | input | 1 | 1 = data address translation enabled |
| in_tlb_hit | input | 1 | 1 = TLB lookup hit |
| in_wr_ok | input | 1 | Write permission of the hit entry |
| in_zone | input | 2 | Zone-protection field for the entry; 2'b00 = no user access |
| in_byte_cnt | input | 7 | String transfer byte count |
| out_dsi | output | 1 | Data storage exception verdict |
| out_tlb_miss | output | 1 | TLB miss exception verdict |
| out_nop | output | 1 | Operation dropped as a no-op |
| out_proceed | output | 1 | Operation goes ahead |

## Verification
The assertions check several properties on every cycle. The result is one-hot, and the flags are quiet after an idle edge. Real mode never faults. Touch classes never fault, read classes always proceed, and zero-length strings always become no-ops. The per-class choice between a data storage fault, a TLB miss and proceeding shows only in the bench scenarios. These compare every verdict with an independent model across privilege, zone, write permission and hit combinations. The distinction between zone and write-permission sensitivity for each class is covered the same way.

// File: rtl/apc_pkg.sv
package apc_pkg;
  localparam int CLS_W = 4;

  typedef enum logic [CLS_W-1:0] {
    OP_LOAD      = 4'd0,
    OP_STORE     = 4'd1,
    OP_DC_CCINV  = 4'd2,
    OP_DC_TOUCH  = 4'd3,
    OP_DC_TOUCHW = 4'd4,
    OP_DC_FLUSH  = 4'd5,
    OP_DC_STBLK  = 4'd6,
    OP_DC_READ   = 4'd7,
    OP_IC_BINV   = 4'd8,
    OP_IC_TOUCH  = 4'd9,
    OP_IC_CCINV  = 4'd10,
    OP_IC_READ   = 4'd11,
    OP_STR_ST    = 4'd12,
    OP_STR_LD    = 4'd13,
    OP_RSV14     = 4'd14,
    OP_RSV15     = 4'd15
  } op_class_e;

  // Per-class protection attributes
  typedef struct packed {
    logic speculative; // drop instead of fault
    logic no_lookup;   // non-specific address, no TLB consult
    logic is_string;   // zero count means no access
    logic wp_check;    // store-like: write permission matters
    logic zone_check;  // unprivileged: zone 00 matters in user mode
  } class_attr_t;

  typedef enum logic [1:0] {
    V_PROCEED = 2'd0,
    V_NOP     = 2'd1,
    V_DSI     = 2'd2,
    V_TLB     = 2'd3
  } verdict_e;
endpackage

// File: rtl/apc_class_decode.sv
module apc_class_decode
  import apc_pkg::*;
(
  input  logic [CLS_W-1:0] cls,
  output class_attr_t      attr
);
  always_comb begin
    attr = '0;
    unique case (op_class_e'(cls))
      OP_LOAD:      attr.zone_check = 1'b1;
      OP_STORE:     begin attr.zone_check = 1'b1; attr.wp_check = 1'b1; end
      OP_DC_CCINV:  attr.wp_check = 1'b1;
      OP_DC_TOUCH,
      OP_DC_TOUCHW,
      OP_IC_TOUCH:  attr.speculative = 1'b1;
      OP_DC_FLUSH,
      OP_DC_STBLK,
      OP_IC_BINV:   attr.zone_check = 1'b1;
      OP_DC_READ,
      OP_IC_READ:   attr.no_lookup = 1'b1;
      OP_IC_CCINV:  attr = '0;
      OP_STR_ST:    begin attr.is_string = 1'b1; attr.wp_check = 1'b1; attr.zone_check = 1'b1; end
      OP_STR_LD:    begin attr.is_string = 1'b1; attr.zone_check = 1'b1; end
      default:      attr.zone_check = 1'b1;
    endcase
  end
endmodule

// File: rtl/apc_verdict.sv
module apc_verdict
  import apc_pkg::*;
(
  input  class_attr_t attr,
  input  logic        priv,
  input  logic        xlate,
  input  logic        tlb_hit,
  input  logic        wr_ok,
  input  logic [1:0]  zone,
  input  logic        cnt_zero,
  output verdict_e    verdict
);
  logic zone_bad;
  logic prot_bad;

  assign zone_bad = (zone == 2'b00) && !priv;
  assign prot_bad = (attr.wp_check && !wr_ok) || (attr.zone_check && zone_bad);

  always_comb begin
    if (attr.is_string && cnt_zero)       verdict = V_NOP;
    else if (!xlate)                      verdict = V_PROCEED;
    else if (attr.no_lookup)              verdict = V_PROCEED;
    else if (attr.speculative)            verdict = (!tlb_hit || zone_bad) ? V_NOP : V_PROCEED;
    else if (!tlb_hit)                    verdict = V_TLB;
    else if (prot_bad)                    verdict = V_DSI;
    else                                  verdict = V_PROCEED;
  end
endmodule

// File: rtl/apc_checker.sv
module apc_checker
  import apc_pkg::*;
#(
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [CLS_W-1:0] in_class,
  input  logic             in_priv,
  input  logic             in_xlate,
  input  logic             in_tlb_hit,
  input  logic             in_wr_ok,
  input  logic [1:0]       in_zone,
  input  logic [CNT_W-1:0] in_byte_cnt,
  output logic             out_dsi,
  output logic             out_tlb_miss,
  output logic             out_nop,
  output logic             out_proceed
);
  class_attr_t attr;
  verdict_e    verdict;
  logic        cnt_zero;

  assign cnt_zero = (in_byte_cnt == '0);

  apc_class_decode u_dec (
    .cls  (in_class),
    .attr (attr)
  );

  apc_verdict u_vrd (
    .attr     (attr),
    .priv     (in_priv),
    .xlate    (in_xlate),
    .tlb_hit  (in_tlb_hit),
    .wr_ok    (in_wr_ok),
    .zone     (in_zone),
    .cnt_zero (cnt_zero),
    .verdict  (verdict)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_dsi      <= 1'b0;
      out_tlb_miss <= 1'b0;
      out_nop      <= 1'b0;
      out_proceed  <= 1'b0;
    end else begin
      out_dsi      <= in_valid && (verdict == V_DSI);
      out_tlb_miss <= in_valid && (verdict == V_TLB);
      out_nop      <= in_valid && (verdict == V_NOP);
      out_proceed  <= in_valid && (verdict == V_PROCEED);
    end
  end

  // R2: exactly one flag after an accepted operation
  a_r2_one_flag: assert property (@(posedge clk) disable iff (!rst_n)
    $past(in_valid) |-> $countones({out_dsi, out_tlb_miss, out_nop, out_proceed}) == 1);

  // R1: quiet after an idle edge
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(in_valid) |-> !(out_dsi || out_tlb_miss || out_nop || out_proceed));

  // R3: real mode never faults
  a_r3_real_no_fault: assert property (@(posedge clk) disable iff (!rst_n)
    $past(in_valid && !in_xlate) |-> !out_dsi && !out_tlb_miss);

  // R7: touch classes never fault
  a_r7_touch_no_fault: assert property (@(posedge clk) disable iff (!rst_n)
    $past(in_valid && (in_class == 4'd3 || in_class == 4'd4 || in_class == 4'd9))
      |-> !out_dsi && !out_tlb_miss);

  // R9: read classes always proceed
  a_r9_read_proceed: assert property (@(posedge clk) disable iff (!rst_n)
    $past(in_valid && (in_class == 4'd7 || in_class == 4'd11)) |-> out_proceed);

  // R10: instruction congruence-class invalidate never gives a data storage fault
  a_r10_iccinv_no_dsi: assert property (@(posedge clk) disable iff (!rst_n)
    $past(in_valid && in_class == 4'd10) |-> !out_dsi);

  // R11: zero-length string is a no-op
  a_r11_zero_string_nop: assert property (@(posedge clk) disable iff (!rst_n)
    $past(in_valid && (in_class == 4'd12 || in_class == 4'd13) && in_byte_cnt == '0)
      |-> out_nop);
endmodule

// File: tb/test_apc_checker.sv
module test_apc_checker;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic [3:0] in_class = '0;
  logic       in_priv = 1'b0;
  logic       in_xlate = 1'b0;
  logic       in_tlb_hit = 1'b0;
  logic       in_wr_ok = 1'b0;
  logic [1:0] in_zone = '0;
  logic [6:0] in_byte_cnt = '0;
  logic       out_dsi, out_tlb_miss, out_nop, out_proceed;

  int checks = 0;
  int bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  apc_checker i_apc_checker (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_class(in_class),
    .in_priv(in_priv), .in_xlate(in_xlate), .in_tlb_hit(in_tlb_hit),
    .in_wr_ok(in_wr_ok), .in_zone(in_zone), .in_byte_cnt(in_byte_cnt),
    .out_dsi(out_dsi), .out_tlb_miss(out_tlb_miss), .out_nop(out_nop),
    .out_proceed(out_proceed)
  );

  // Expected flags {dsi, tlb, nop, proceed}, from the requirements
  function automatic logic [3:0] model(input logic [3:0] c, input logic p, input logic x,
                                       input logic h, input logic w, input logic [1:0] z,
                                       input logic [6:0] n);
    logic ub;
    ub = (z == 2'b00) && !p;
    if ((c == 12 || c == 13) && n == 0) return 4'b0010;        // R11
    if (!x) return 4'b0001;                                    // R3
    case (c)
      3, 4, 9:  return (!h || ub) ? 4'b0010 : 4'b0001;         // R7
      7, 11:    return 4'b0001;                                // R9
      default: ;
    endcase
    if (!h) return 4'b0100;                                    // R4
    case (c)
      1, 12:    return (ub || !w) ? 4'b1000 : 4'b0001;         // R5 R11
      2:        return !w ? 4'b1000 : 4'b0001;                 // R6
      10:       return 4'b0001;                                // R10
      default:  return ub ? 4'b1000 : 4'b0001;                 // R5 R8 R12
    endcase
  endfunction

  function automatic string tag(input logic [3:0] c, input logic x, input logic h, input logic [6:0] n);
    if ((c == 12 || c == 13) && n == 0) return "R11";
    if (!x) return "R3";
    case (c)
      3, 4, 9: return "R7";
      7, 11:   return "R9";
      default: ;
    endcase
    if (!h) return "R4";
    case (c)
      0, 1:     return "R5";
      2:        return "R6";
      5, 6, 8:  return "R8";
      10:       return "R10";
      12, 13:   return "R11";
      default:  return "R12";
    endcase
  endfunction

  task automatic check(input string rq, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b", rq, act, exp);
    end
  endtask

  task automatic run_op(input logic [3:0] c, input logic p, input logic x, input logic h,
                        input logic w, input logic [1:0] z, input logic [6:0] n);
    logic [3:0] e;
    @(negedge clk);
    in_valid = 1; in_class = c; in_priv = p; in_xlate = x;
    in_tlb_hit = h; in_wr_ok = w; in_zone = z; in_byte_cnt = n;
    e = model(c, p, x, h, w, z, n);
    @(negedge clk);
    in_valid = 0;
    check(tag(c, x, h, n), {out_dsi, out_tlb_miss, out_nop, out_proceed}, e);
    check("R2", 4'(($countones({out_dsi, out_tlb_miss, out_nop, out_proceed}) == 1) ? 1 : 0), 4'd1);
  endtask

  initial begin
    #(8 * 200000);
    bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check("R1", {out_dsi, out_tlb_miss, out_nop, out_proceed}, 4'b0000);
    rst_n = 1;
    // directed corners
    run_op(0, 0, 1, 1, 1, 2'b00, 5);   // R5 load user zone00 faults
    run_op(0, 1, 1, 1, 1, 2'b00, 5);   // R5 supervisor ok
    run_op(1, 1, 1, 1, 0, 2'b01, 5);   // R5 store wr 0
    run_op(2, 0, 1, 1, 1, 2'b00, 5);   // R6 zone ignored
    run_op(2, 1, 1, 1, 0, 2'b01, 5);   // R6 wr 0 faults
    run_op(2, 1, 1, 0, 1, 2'b01, 5);   // R4 miss
    run_op(3, 0, 1, 0, 1, 2'b01, 5);   // R7 miss -> nop
    run_op(4, 0, 1, 1, 1, 2'b00, 5);   // R7 zone -> nop
    run_op(9, 0, 1, 1, 0, 2'b10, 5);   // R7 proceed
    run_op(5, 0, 1, 1, 0, 2'b01, 5);   // R8 wr ignored
    run_op(6, 0, 1, 1, 1, 2'b00, 5);   // R8 zone faults
    run_op(8, 0, 1, 1, 1, 2'b00, 5);   // R8
    run_op(7, 0, 1, 0, 0, 2'b00, 5);   // R9
    run_op(11, 0, 1, 0, 0, 2'b00, 5);  // R9
    run_op(10, 0, 1, 1, 0, 2'b00, 5);  // R10 no dsi
    run_op(10, 0, 1, 0, 0, 2'b00, 5);  // R10 miss
    run_op(12, 0, 1, 0, 0, 2'b00, 0);  // R11 zero store
    run_op(13, 0, 1, 0, 0, 2'b00, 0);  // R11 zero load
    run_op(12, 1, 1, 1, 0, 2'b11, 1);  // R11 store wr 0
    run_op(13, 0, 1, 1, 0, 2'b11, 127);// R11 load wr ignored
    run_op(14, 0, 1, 1, 1, 2'b00, 5);  // R12
    run_op(15, 0, 1, 1, 0, 2'b01, 5);  // R12 wr ignored
    run_op(1, 0, 0, 0, 0, 2'b00, 5);   // R3 real mode
    @(negedge clk);
    check("R1", {out_dsi, out_tlb_miss, out_nop, out_proceed}, 4'b0000);
    // random mix
    for (int i = 0; i < 3000; i++) begin
      logic [6:0] n;
      n = ($urandom % 4 == 0) ? 7'd0 : 7'($urandom);
      run_op(4'($urandom), 1'($urandom), ($urandom % 4) != 0, ($urandom % 3) != 0,
             1'($urandom), 2'($urandom), n);
      if (i % 50 == 0) begin
        @(negedge clk);
        check("R1", {out_dsi, out_tlb_miss, out_nop, out_proceed}, 4'b0000);
      end
    end
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule